// File: doc/BRIEF.md
# Error Status and Reporting Register

This block holds a 16-bit error status word for a host-bridge style memory controller. Four hardware conditions each latch into their own sticky flag: a software-raised event, a thermal trip that has actually produced an interrupt, a locked access that targets memory space outside DRAM, and a backlog of pending memory refreshes. A flag stays set until software writes a 1 to its bit position. Writing a 0 leaves it alone.

When a flag goes from 0 to 1, the block can request a system-error message. This happens only when that flag's own enable bit and the global system-error enable are both set. The request is a single-cycle pulse. The thermal path also gates its interrupt. A trip is sent only if it is routed to exactly one interrupt type (SMI, SCI or SERR), and only while the thermal flag is clear.

The refresh backlog is a saturating counter. Refresh requests raise it and refresh completions lower it. When the counter reaches the threshold, the backlog flag is set.

Top module: `fault_status_unit`

## Requirements
- R1: After reset the register reads 0000h, and bits 15:13, 10 and 7:0 always read as 0.
- R2: The register is returned on `reg_rdata_o` only when `reg_addr_i` equals C8h. Any other address reads 0.
- R3: A write to offset C8h clears each flag whose write-data bit is 1. Write-data bits of 0 have no effect.
- R4: A flag is set on its condition whatever the values of `errcmd_en_i` and `glb_serr_en_i`.
- R5: `serr_req_o` is high in the cycle after a flag rises from 0 to 1, but only if that flag's `errcmd_en_i` bit and `glb_serr_en_i` were both 1 in the event cycle.
- R6: A cycle with `sw_evt_i` high sets bit 12 at the next clock edge.
- R7: A thermal trip whose `therm_route_i` has exactly one bit set (bit0 SMI, bit1 SCI, bit2 SERR) pulses that same bit on `therm_irq_o` for one cycle and sets bit 11 at the next edge. While bit 11 is set, a trip sends nothing.
- R8: A thermal trip with zero or with two or more route bits set sends no interrupt and does not set bit 11.
- R9: A cycle with `lock_nondram_i` high sets bit 9 at the next clock edge.
- R10: The pending-refresh count goes up by one for a request, down by one for a completion, and is unchanged when both or neither arrive. It saturates at 0 and at its maximum. Bit 8 is set at the edge after the count is at or above RFSH_THRESH (1024).
- R11: When a hardware set and a software clear hit the same bit in the same cycle, the bit ends up set.
- R12: A flag that is already set raises no further `serr_req_o` when its condition recurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_evt_i | input | 1 | Software-generated SMI event |
| therm_trip_i | input | 1 | Thermal trip point crossed |
| therm_route_i | input | 3 | Thermal routing enables: bit0 SMI, bit1 SCI, bit2 SERR |
| lock_nondram_i | input | 1 | Locked access to non-DRAM memory space |
| rfsh_req_i | input | 1 | Refresh enqueued |
| rfsh_done_i | input | 1 | Refresh completed |
| errcmd_en_i | input | 16 | Per-bit system-error enables |
| glb_serr_en_i | input | 1 | Global system-error enable |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address offset |
| reg_wdata_i | input | 16 | Write data, where 1 clears the flag |
| reg_rdata_o | output | 16 | Read data |
| serr_req_o | output | 1 | One-cycle system-error message request |
| therm_irq_o | output | 3 | One-cycle thermal interrupt sent, by type |

## Verification
Every flag, and the message pulse it causes, becomes visible one clock edge after its event. This means a stuck or lost flag state shows on `reg_rdata_o` at the very next read. A wrong rise detector shows as a missing or repeated `serr_req_o` pulse in that same cycle. The refresh counter is hidden, so its errors appear late. A wrap or an off-by-one at the threshold shows only as bit 8 setting one edge too early or too late, or not at all, after a long run of requests. The bench therefore counts exact request totals across the threshold, and again after driving the counter down past zero.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int REG_W = 16;
  localparam logic [7:0] REG_OFFSET = 8'hC8;

  localparam int BIT_SWEV  = 12;
  localparam int BIT_THERM = 11;
  localparam int BIT_LOCK  = 9;
  localparam int BIT_RFSH  = 8;

  localparam logic [REG_W-1:0] IMPL_MASK =
    (REG_W'(1) << BIT_SWEV) | (REG_W'(1) << BIT_THERM) |
    (REG_W'(1) << BIT_LOCK) | (REG_W'(1) << BIT_RFSH);

  // next value of a sticky W1C flag word: hardware set beats software clear
  function automatic logic [REG_W-1:0] fn_flag_next(
    input logic [REG_W-1:0] cur,
    input logic [REG_W-1:0] set,
    input logic [REG_W-1:0] clr);
    return ((cur & ~clr) | set) & IMPL_MASK;
  endfunction

  // rising flags that are permitted to request a message
  function automatic logic [REG_W-1:0] fn_rise(
    input logic [REG_W-1:0] nxt,
    input logic [REG_W-1:0] cur,
    input logic [REG_W-1:0] en);
    return nxt & ~cur & en;
  endfunction

  // saturating up/down step on a 32-bit carrier
  function automatic logic [31:0] fn_sat_step(
    input logic [31:0] cnt,
    input logic        up,
    input logic        dn,
    input logic [31:0] max);
    logic [31:0] r;
    r = cnt;
    if (up && !dn && cnt != max) r = cnt + 32'd1;
    else if (dn && !up && cnt != 32'd0) r = cnt - 32'd1;
    return r;
  endfunction
endpackage

// File: rtl/fsr_rfsh_backlog.sv
module fsr_rfsh_backlog #(
  parameter int THRESH = 1024,
  parameter int CNT_W  = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic done_i,
  output logic backlog_o
);
  import fsr_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_THR = CNT_W'(THRESH);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = CNT_W'(fn_sat_step(32'(cnt_q), req_i, done_i, 32'(CNT_MAX)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  assign backlog_o = (cnt_q >= CNT_THR);

  p_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && req_i && !done_i) |=> (cnt_q == CNT_MAX));
  p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && done_i && !req_i) |=> (cnt_q == '0));
endmodule

// File: rtl/fsr_therm_gate.sv
module fsr_therm_gate #(
  parameter int NROUTE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trip_i,
  input  logic [NROUTE-1:0] route_i,
  input  logic              busy_i,
  output logic              sent_o,
  output logic [NROUTE-1:0] irq_o
);
  logic [NROUTE-1:0] irq_q;
  logic              legal_w;

  assign legal_w = $onehot(route_i);
  assign sent_o  = trip_i && legal_w && !busy_i;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= sent_o ? route_i : '0;
  end

  assign irq_o = irq_q;

  p_one_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_q));
  p_therm_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> (irq_q == '0));
endmodule

// File: rtl/fsr_flag_bank.sv
module fsr_flag_bank
  import fsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] set_i,
  input  logic [REG_W-1:0] clr_i,
  output logic [REG_W-1:0] flags_o,
  output logic [REG_W-1:0] next_o
);
  logic [REG_W-1:0] nxt_w;

  assign nxt_w  = fn_flag_next(flags_o, set_i, clr_i);
  assign next_o = nxt_w;

  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    if (IMPL_MASK[b]) begin : g_impl
      logic f_q;
      always_ff @(posedge clk) begin
        if (!rst_n) f_q <= 1'b0;
        else        f_q <= nxt_w[b];
      end
      assign flags_o[b] = f_q;

      p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[b] |=> flags_o[b]);
      p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[b] && !set_i[b]) |=> !flags_o[b]);
      p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[b] && !clr_i[b]) |=> flags_o[b]);
    end else begin : g_rsvd
      assign flags_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/fault_status_unit.sv
module fault_status_unit #(
  parameter int RFSH_THRESH = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_evt_i,
  input  logic        therm_trip_i,
  input  logic [2:0]  therm_route_i,
  input  logic        lock_nondram_i,
  input  logic        rfsh_req_i,
  input  logic        rfsh_done_i,
  input  logic [15:0] errcmd_en_i,
  input  logic        glb_serr_en_i,
  input  logic        reg_wr_i,
  input  logic [7:0]  reg_addr_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  output logic        serr_req_o,
  output logic [2:0]  therm_irq_o
);
  import fsr_pkg::*;

  localparam int RFSH_CNT_W = $clog2(RFSH_THRESH) + 1;

  logic             hit_w;
  logic             backlog_w;
  logic             therm_sent_w;
  logic [REG_W-1:0] set_w;
  logic [REG_W-1:0] clr_w;
  logic [REG_W-1:0] flags_w;
  logic [REG_W-1:0] next_w;
  logic [REG_W-1:0] rise_w;
  logic             serr_q;

  assign hit_w = (reg_addr_i == REG_OFFSET);

  fsr_rfsh_backlog #(.THRESH(RFSH_THRESH), .CNT_W(RFSH_CNT_W)) u_rfsh (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (rfsh_req_i),
    .done_i    (rfsh_done_i),
    .backlog_o (backlog_w)
  );

  fsr_therm_gate #(.NROUTE(3)) u_therm (
    .clk     (clk),
    .rst_n   (rst_n),
    .trip_i  (therm_trip_i),
    .route_i (therm_route_i),
    .busy_i  (flags_w[BIT_THERM]),
    .sent_o  (therm_sent_w),
    .irq_o   (therm_irq_o)
  );

  always_comb begin
    set_w            = '0;
    set_w[BIT_SWEV]  = sw_evt_i;
    set_w[BIT_THERM] = therm_sent_w;
    set_w[BIT_LOCK]  = lock_nondram_i;
    set_w[BIT_RFSH]  = backlog_w;
    clr_w            = (reg_wr_i && hit_w) ? reg_wdata_i : '0;
  end

  fsr_flag_bank u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (set_w),
    .clr_i   (clr_w),
    .flags_o (flags_w),
    .next_o  (next_w)
  );

  assign rise_w = fn_rise(next_w, flags_w, errcmd_en_i & {REG_W{glb_serr_en_i}});

  always_ff @(posedge clk) begin
    if (!rst_n) serr_q <= 1'b0;
    else        serr_q <= |rise_w;
  end

  assign serr_req_o  = serr_q;
  assign reg_rdata_o = hit_w ? flags_w : '0;

  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata_o & ~IMPL_MASK) == '0);
  p_serr_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(serr_req_o) |-> $past(glb_serr_en_i));
  p_serr_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_w & errcmd_en_i) == (errcmd_en_i & IMPL_MASK) && glb_serr_en_i
     && $stable(errcmd_en_i)) |=> !serr_req_o);
endmodule

// File: tb/fault_status_unit_tb_top.sv
`timescale 1ns/1ps
module fault_status_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_evt_i = 1'b0, therm_trip_i = 1'b0, lock_nondram_i = 1'b0;
  logic [2:0]  therm_route_i = 3'b000;
  logic        rfsh_req_i = 1'b0, rfsh_done_i = 1'b0;
  logic [15:0] errcmd_en_i = 16'h0000;
  logic        glb_serr_en_i = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [7:0]  reg_addr_i = 8'hC8;
  logic [15:0] reg_wdata_i = 16'h0000;
  logic [15:0] reg_rdata_o;
  logic        serr_req_o;
  logic [2:0]  therm_irq_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fault_status_unit dut_i (.*);

  typedef struct {
    int          kind;   // 0 read data, 1 serr pulse, 2 thermal irq
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];
  item_t it;
  logic [15:0] act;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_item(input int kind, input logic [15:0] exp, input string tag);
    item_t x;
    x.kind = kind; x.exp = exp; x.tag = tag;
    sbq.push_back(x);
  endtask

  task automatic w1c(input logic [15:0] d);
    reg_wr_i = 1'b1; reg_wdata_i = d;
    step();
    reg_wr_i = 1'b0; reg_wdata_i = 16'h0000;
  endtask

  // monitor: compares everything queued for this cycle
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      it = sbq.pop_front();
      case (it.kind)
        0:       act = reg_rdata_o;
        1:       act = {15'd0, serr_req_o};
        default: act = {13'd0, therm_irq_o};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    expect_item(0, 16'h0000, "R1 reset value");
    step();
    rst_n = 1'b1;
    step();
    expect_item(0, 16'h0000, "R1 after reset");

    // R6 software event
    sw_evt_i = 1; step(); sw_evt_i = 0;
    expect_item(0, 16'h1000, "R6 sw event sets bit12");
    expect_item(1, 16'h0000, "R5 no request without enables");
    step();

    // R2 address decode
    reg_addr_i = 8'hC4;
    expect_item(0, 16'h0000, "R2 other offset reads zero");
    step();
    reg_addr_i = 8'hC8;

    // R3 write-0 no effect, write-1 clears
    w1c(16'h0000);
    expect_item(0, 16'h1000, "R3 zero write keeps flag");
    w1c(16'hFFFF);
    expect_item(0, 16'h0000, "R3 one write clears");

    // R9, R5, R12
    errcmd_en_i = 16'h0200; glb_serr_en_i = 1;
    lock_nondram_i = 1; step(); lock_nondram_i = 0;
    expect_item(0, 16'h0200, "R9 lock flag");
    expect_item(1, 16'h0001, "R5 request on rise");
    step();
    expect_item(1, 16'h0000, "R12 pulse is one cycle");
    lock_nondram_i = 1; step(); lock_nondram_i = 0;
    expect_item(1, 16'h0000, "R12 no request while set");
    w1c(16'h0200);
    expect_item(0, 16'h0000, "R3 clear lock");

    // R4 flags set without global enable
    glb_serr_en_i = 0;
    lock_nondram_i = 1; step(); lock_nondram_i = 0;
    expect_item(0, 16'h0200, "R4 set with global off");
    expect_item(1, 16'h0000, "R5 no request with global off");
    w1c(16'h0200);

    // R5 per-bit enable missing
    glb_serr_en_i = 1;
    sw_evt_i = 1; step(); sw_evt_i = 0;
    expect_item(0, 16'h1000, "R4 set with bit enable off");
    expect_item(1, 16'h0000, "R5 no request with bit enable off");

    // R11 set beats clear
    sw_evt_i = 1; reg_wr_i = 1; reg_wdata_i = 16'h1000;
    step();
    sw_evt_i = 0; reg_wr_i = 0; reg_wdata_i = 16'h0000;
    expect_item(0, 16'h1000, "R11 set wins over clear");
    w1c(16'h1000);
    expect_item(0, 16'h0000, "R3 clear sw flag");

    // R7 thermal
    therm_route_i = 3'b001; therm_trip_i = 1; step(); therm_trip_i = 0;
    expect_item(2, 16'h0001, "R7 SMI sent");
    expect_item(0, 16'h0800, "R7 thermal flag");
    step();
    expect_item(2, 16'h0000, "R7 irq one cycle");
    therm_trip_i = 1; step(); therm_trip_i = 0;
    expect_item(2, 16'h0000, "R7 blocked while flag set");
    w1c(16'h0800);
    expect_item(0, 16'h0000, "R3 clear thermal");
    therm_route_i = 3'b100; therm_trip_i = 1; step(); therm_trip_i = 0;
    expect_item(2, 16'h0004, "R7 SERR route sent");
    w1c(16'h0800);

    // R8 illegal routes
    therm_route_i = 3'b110; therm_trip_i = 1; step(); therm_trip_i = 0;
    expect_item(2, 16'h0000, "R8 two routes not sent");
    expect_item(0, 16'h0000, "R8 no flag on two routes");
    therm_route_i = 3'b000; therm_trip_i = 1; step(); therm_trip_i = 0;
    expect_item(2, 16'h0000, "R8 no route not sent");
    expect_item(0, 16'h0000, "R8 no flag on no route");

    // R10 refresh backlog
    rfsh_req_i = 1;
    repeat (1024) step();
    rfsh_req_i = 0;
    expect_item(0, 16'h0000, "R10 not yet at threshold edge");
    step();
    expect_item(0, 16'h0100, "R10 backlog flag at 1024");
    rfsh_done_i = 1; step(); rfsh_done_i = 0;   // count 1023
    w1c(16'h0100);
    expect_item(0, 16'h0000, "R10 clear below threshold");
    rfsh_req_i = 1; rfsh_done_i = 1; step();
    rfsh_req_i = 0; rfsh_done_i = 0; step();
    expect_item(0, 16'h0000, "R10 req and done cancel");
    rfsh_req_i = 1; step(); rfsh_req_i = 0;
    expect_item(0, 16'h0000, "R10 one cycle latency");
    step();
    expect_item(0, 16'h0100, "R10 flag after reaching threshold");
    rfsh_done_i = 1;
    repeat (1100) step();
    rfsh_done_i = 0;
    w1c(16'h0100);
    expect_item(0, 16'h0000, "R10 clear at zero count");
    rfsh_req_i = 1;
    repeat (1023) step();
    rfsh_req_i = 0;
    step(); step();
    expect_item(0, 16'h0000, "R10 saturated at zero");
    rfsh_req_i = 1; step(); rfsh_req_i = 0;
    step();
    expect_item(0, 16'h0100, "R10 threshold after saturation");
    step();
    step();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule